// File: doc/BRIEF.md
# Configuration Header Identity, Command and Status Block

This block holds the first two doublewords of a type-0 configuration header for a bridge-class device: the identity doubleword and the command/status doubleword. A configuration agent reaches it through a simple doubleword-indexed port. The port carries a read strobe, a write strobe, byte enables and write data, and it returns read data one cycle after the read strobe.

Most command bits are tied off. Three command bits can be written, and the block drives them out as control levels: the system-error driver gate, the parity-check enable and the bus-master permission. Single-cycle event pulses from the bus engine set five sticky status flags. Software clears each flag by writing 1 to it. The device-select timing field is fixed at medium.

Top module: `cfg_hdr_regs`

## Requirements
- R1: A read of doubleword index 0 returns 32'h0001_1078: vendor code 16'h1078 in bits 15:0 and device code 16'h0001 in bits 31:16. Writes to index 0 change nothing.
- R2: After reset, a read of index 1 returns 32'h0280_0007: command 16'h0007 in bits 15:0 and status 16'h0280 in bits 31:16.
- R3: Command bits 15:10, 9, 7, 5, 4 and 3 always read 0, and command bits 1:0 always read 1, whatever is written.
- R4: Command bit 8 is writable. Its value drives serr_drv_en_o.
- R5: Command bit 6 is writable. Its value drives parity_chk_en_o.
- R6: Command bit 2 is writable. Its value drives bus_master_en_o.
- R7: Status bits 10:9 always read 2'b01 and status bit 7 always reads 1. All other non-flag status bits read 0.
- R8: A pulse on mst_abort_i, tgt_abort_rx_i, tgt_abort_tx_i or serr_evt_i sets status bit 13, 12, 11 or 14 respectively. The bit stays set until a write of 1 to that bit position.
- R9: A pulse on parity_err_i sets status bit 15 only while command bit 6 is 1.
- R10: Writing 1 to a status flag bit clears it. Writing 0 leaves it unchanged.
- R11: If a flag's event and a clearing write fall in the same cycle, the flag ends the cycle at 1.
- R12: Byte enables gate the writes. Bytes 0–1 of index 1 reach only the command register, and bytes 2–3 reach only the status register.
- R13: Any index other than 0 or 1 reads as 0. Writes to such an index have no effect.
- R14: rd_data_o is registered. It is valid in the cycle after rd_en_i and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_i | input | IDX_W | Doubleword index |
| be_i | input | 4 | Byte enables |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| parity_err_i | input | 1 | Parity error detected event |
| serr_evt_i | input | 1 | System error driven event |
| mst_abort_i | input | 1 | Master abort received event |
| tgt_abort_rx_i | input | 1 | Target abort received event |
| tgt_abort_tx_i | input | 1 | Target abort signaled event |
| serr_drv_en_o | output | 1 | System-error driver gate |
| parity_chk_en_o | output | 1 | Parity checking enable |
| bus_master_en_o | output | 1 | Bus-master permission |

## Verification
The hardest case to reach from the ports is an event pulse landing in the same clock as a clearing write to its own flag. The bench drives both in one cycle and then reads the flag back. It also covers the parity flag's dependence on the command bit, toggling bit 6 around parity pulses. Every flag is swept against all sixteen byte-enable patterns, so that the enable gating of both the clear and the command update is checked arithmetically.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam logic [15:0] VENDOR_CODE = 16'h1078;
  localparam logic [15:0] DEVICE_CODE = 16'h0001;
  localparam int unsigned NUM_FLAGS = 5;
  // flag order: 0 det-parity(15), 1 sys-err(14), 2 mabort(13), 3 tabort-rx(12), 4 tabort-tx(11)
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{15, 14, 13, 12, 11};
  localparam logic [1:0] DEVSEL_MEDIUM = 2'b01;
  typedef struct packed {
    logic serr_gate;
    logic par_chk;
    logic bus_mst;
  } cmd_ctl_t;
endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
  import cfg_hdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  logic [15:0] wdata_i,
  output cmd_ctl_t   ctl_o,
  output logic [15:0] cmd_o
);
  cmd_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{serr_gate: 1'b0, par_chk: 1'b0, bus_mst: 1'b1};
    end else begin
      if (wr_hi_i) ctl_q.serr_gate <= wdata_i[8];
      if (wr_lo_i) begin
        ctl_q.par_chk <= wdata_i[6];
        ctl_q.bus_mst <= wdata_i[2];
      end
    end
  end

  always_comb begin
    cmd_o    = 16'h0003;
    cmd_o[8] = ctl_q.serr_gate;
    cmd_o[6] = ctl_q.par_chk;
    cmd_o[2] = ctl_q.bus_mst;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/cfg_stat_flag.sv
module cfg_stat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/cfg_stat_reg.sv
module cfg_stat_reg
  import cfg_hdr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [15:0] wdata_i,
  input  flag_vec_t   evt_i,
  output logic [15:0] stat_o
);
  flag_vec_t flags;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    localparam int unsigned POS = FLAG_POS[g];
    logic clr;
    assign clr = (POS >= 8) ? (wr_hi_i & wdata_i[POS]) : (wr_lo_i & wdata_i[POS]);
    cfg_stat_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[g]),
      .clr_i  (clr),
      .flag_o (flags[g])
    );
  end

  always_comb begin
    stat_o       = 16'h0080;
    stat_o[10:9] = DEVSEL_MEDIUM;
    for (int i = 0; i < NUM_FLAGS; i++) stat_o[FLAG_POS[i]] = flags[i];
  end
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             rd_en_i,
  output logic [31:0]      rd_data_o,
  input  logic             parity_err_i,
  input  logic             serr_evt_i,
  input  logic             mst_abort_i,
  input  logic             tgt_abort_rx_i,
  input  logic             tgt_abort_tx_i,
  output logic             serr_drv_en_o,
  output logic             parity_chk_en_o,
  output logic             bus_master_en_o
);
  localparam logic [IDX_W-1:0] IDX_ID  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(1);

  logic        hit_cs;
  logic [15:0] cmd_w, stat_w;
  cmd_ctl_t    ctl;
  flag_vec_t   evt;
  logic [31:0] rd_mux;

  assign hit_cs = wr_en_i && (idx_i == IDX_CMD);

  cfg_cmd_reg u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (hit_cs & be_i[0]),
    .wr_hi_i (hit_cs & be_i[1]),
    .wdata_i (wr_data_i[15:0]),
    .ctl_o   (ctl),
    .cmd_o   (cmd_w)
  );

  assign evt = {tgt_abort_tx_i, tgt_abort_rx_i, mst_abort_i, serr_evt_i,
                parity_err_i & ctl.par_chk};

  cfg_stat_reg u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (hit_cs & be_i[2]),
    .wr_hi_i (hit_cs & be_i[3]),
    .wdata_i (wr_data_i[31:16]),
    .evt_i   (evt),
    .stat_o  (stat_w)
  );

  always_comb begin
    unique case (idx_i)
      IDX_ID:  rd_mux = {DEVICE_CODE, VENDOR_CODE};
      IDX_CMD: rd_mux = {stat_w, cmd_w};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  assign serr_drv_en_o   = ctl.serr_gate;
  assign parity_chk_en_o = ctl.par_chk;
  assign bus_master_en_o = ctl.bus_mst;
endmodule

// File: rtl/cfg_hdr_regs_chk.sv
module cfg_hdr_regs_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] idx_i,
  input logic [3:0]       be_i,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic             rd_en_i,
  input logic [31:0]      rd_data_o,
  input logic             parity_err_i,
  input logic             serr_evt_i,
  input logic             mst_abort_i,
  input logic             tgt_abort_rx_i,
  input logic             tgt_abort_tx_i,
  input logic             serr_drv_en_o,
  input logic             parity_chk_en_o,
  input logic             bus_master_en_o
);
  logic rd_cmd_q, rd_id_q, rd_oth_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cmd_q <= 1'b0; rd_id_q <= 1'b0; rd_oth_q <= 1'b0;
    end else begin
      rd_cmd_q <= rd_en_i && idx_i == IDX_W'(1);
      rd_id_q  <= rd_en_i && idx_i == IDX_W'(0);
      rd_oth_q <= rd_en_i && idx_i > IDX_W'(1);
    end
  end

  // R1
  id_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_id_q |-> rd_data_o == 32'h0001_1078);
  // R3
  cmd_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_q |-> (rd_data_o[15:9] == 7'd0 && rd_data_o[7] == 1'b0 &&
                  rd_data_o[5:3] == 3'd0 && rd_data_o[1:0] == 2'b11));
  // R7
  stat_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_q |-> (rd_data_o[26:16] == 11'h280));
  // R13
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oth_q |-> rd_data_o == 32'd0);
  // R14
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R4
  serr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && be_i[1] && idx_i == IDX_W'(1)) |=> $stable(serr_drv_en_o));
  // R5
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && be_i[0] && idx_i == IDX_W'(1)) |=> $stable(parity_chk_en_o));
  // R6
  bm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && be_i[0] && idx_i == IDX_W'(1)) |=> bus_master_en_o == $past(wr_data_i[2]));
endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/cfg_hdr_regs_test.sv
module cfg_hdr_regs_test;
  localparam int IDX_W = 6;
  logic clk = 0, rst_ni = 0;
  logic [IDX_W-1:0] idx = '0;
  logic [3:0] be = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wdata = '0, rdata;
  logic pe = 0, se = 0, ma = 0, tr = 0, tt = 0;
  logic serr_o, par_o, bm_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cfg_hdr_regs #(.IDX_W(IDX_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .idx_i(idx), .be_i(be), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata),
    .parity_err_i(pe), .serr_evt_i(se), .mst_abort_i(ma),
    .tgt_abort_rx_i(tr), .tgt_abort_tx_i(tt),
    .serr_drv_en_o(serr_o), .parity_chk_en_o(par_o), .bus_master_en_o(bm_o));

  // model: command writable bits {8,6,2}, flags {15..11}
  logic [15:0] m_cmd, m_stat;
  function automatic logic [31:0] exp_rd(int i);
    if (i == 0) return 32'h0001_1078;
    if (i == 1) return {m_stat | 16'h0280, m_cmd | 16'h0003};
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int i, logic [3:0] b, logic [31:0] d);
    @(negedge clk); idx = i[IDX_W-1:0]; be = b; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (i == 1) begin
      if (b[1]) m_cmd[8] = d[8];
      if (b[0]) begin m_cmd[6] = d[6]; m_cmd[2] = d[2]; end
      if (b[3]) m_stat[15:11] = m_stat[15:11] & ~d[31:27];
    end
  endtask

  task automatic rd(int i, output logic [31:0] v);
    @(negedge clk); idx = i[IDX_W-1:0]; rd_en = 1;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic pulse(logic [4:0] e);  // {pe,se,ma,tr,tt}
    @(negedge clk); {pe, se, ma, tr, tt} = e;
    @(negedge clk); {pe, se, ma, tr, tt} = '0;
    if (e[4] && m_cmd[6]) m_stat[15] = 1;
    m_stat[14:11] = m_stat[14:11] | e[3:0];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_cmd = 16'h0004; m_stat = 16'h0000;
    repeat (3) @(negedge clk); rst_ni = 1;
    chk("R14 reset rdata", rdata, 32'd0);
    rd(1, v); chk("R2 reset value", v, 32'h0280_0007);
    chk("R6 reset bm", {31'd0, bm_o}, 32'd1);
    rd(0, v); chk("R1 id", v, 32'h0001_1078);
    wr(0, 4'hF, 32'hFFFF_FFFF); rd(0, v); chk("R1 id write ignored", v, 32'h0001_1078);
    // R13 unused indices
    for (int i = 2; i < 64; i++) begin
      wr(i, 4'hF, 32'hFFFF_FFFF); rd(i, v); chk("R13 unused", v, 32'd0);
    end
    rd(1, v); chk("R13 no side effect", v, exp_rd(1));
    // R3 R4 R5 R6 R12: sweep byte enables and command patterns
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 8; p++) begin
        logic [31:0] d;
        d = 32'h0000_FEB8 | ((p & 1) ? 32'h100 : 0) | ((p & 2) ? 32'h40 : 0)
          | ((p & 4) ? 32'h4 : 0);
        wr(1, b[3:0], d); rd(1, v);
        chk("R3 R12 cmd readback", v, exp_rd(1));
        chk("R4 serr out", {31'd0, serr_o}, {31'd0, m_cmd[8]});
        chk("R5 par out", {31'd0, par_o}, {31'd0, m_cmd[6]});
        chk("R6 bm out", {31'd0, bm_o}, {31'd0, m_cmd[2]});
      end
    end
    // R8 R10 R12 flag set and clear under each byte enable
    for (int f = 0; f < 5; f++) begin
      for (int b = 0; b < 16; b++) begin
        pulse(5'b1 << f);
        if (f == 4) begin wr(1, 4'b0001, 32'h40); pulse(5'b10000); end
        rd(1, v); chk("R8 R9 flag set", v, exp_rd(1));
        wr(1, b[3:0], 32'hFFFF_0000 | {16'd0, m_cmd}); rd(1, v);
        chk("R10 R12 flag clear", v, exp_rd(1));
        wr(1, 4'hF, 32'hFFFF_0000 | {16'd0, m_cmd});
      end
    end
    // R10 write 0 leaves flags
    pulse(5'b01111); wr(1, 4'hF, {16'd0, m_cmd}); rd(1, v);
    chk("R10 zero write", v, exp_rd(1));
    chk("R8 all set", {27'd0, v[31:27]}, 32'h0F);
    wr(1, 4'hF, 32'hFFFF_0000 | {16'd0, m_cmd});
    // R9 parity ignored when check disabled
    wr(1, 4'b0001, 32'h0); pulse(5'b10000); rd(1, v);
    chk("R9 parity masked", {31'd0, v[31]}, 32'd0);
    // R11 event coincident with clear
    for (int f = 0; f < 5; f++) begin
      wr(1, 4'b0001, 32'h44);
      @(negedge clk); idx = 1; be = 4'b1000; wdata = 32'hF800_0000; wr_en = 1;
      {pe, se, ma, tr, tt} = 5'b1 << f;
      @(negedge clk); wr_en = 0; {pe, se, ma, tr, tt} = '0;
      rd(1, v);
      chk("R11 set wins", {27'd0, v[31:27]}, 32'(5'b1 << f));
      wr(1, 4'b1000, 32'hF800_0000);
    end
    // R14 hold without read
    rd(0, v); wr(1, 4'hF, 32'h0); repeat (3) @(negedge clk);
    chk("R14 hold", rdata, 32'h0001_1078);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule